// File: doc/BRIEF.md
# APS Byte Persistence Monitor

This block watches the automatic protection switching value carried in the K1 and K2 line overhead bytes of a received frame. Once per frame, on a sample strobe, it forms a 13-bit value from all of K1 and the upper five bits of K2. It compares that value with the value sampled in the previous frame. A value is accepted into the output register only after it has arrived unchanged in a programmable number of back-to-back frames. A change in the accepted value sets a sticky delta flag.

A second counter tracks how many successive frames have gone by without any frame meeting the acceptance criterion. When that count reaches its own programmable limit, a sticky inconsistency event flag is set. This counter is cleared when the framer reports out-of-frame and when a B1 parity error is reported. The persistence counter is also cleared by out-of-frame. Each sticky flag has a clear pulse and a mask, and drives a masked interrupt. The delta flag also drives a dedicated protection-switching interrupt, which has its own mask.

Top module: `aps_persist_mon`

## Requirements
- R1: The monitored value is 13 bits wide: bits 12..5 are K1[7:0] and bits 4..0 are K2[7:3]. K2[2:0] has no effect on matching or on the accepted value.
- R2: A sampled value is copied to `aps_val_o` on the strobe of the frame in which it has been seen in `persist_thr_i` consecutive frames. A sample that differs from the previous frame's sample restarts the run at one.
- R3: When an accepted value differs from the value already held, `delta_o` is set and stays set. A value that is accepted again without change does not set it, and `aps_val_o` changes only on a strobe taken outside out-of-frame.
- R4: `event_o` is set when `incons_thr_i` successive strobed frames pass with no frame accepted. The count restarts after each report and after every accepted frame.
- R5: While `oof_i` is high the persistence run and the inconsistency count are cleared, and a strobe taken in that cycle is ignored. After `oof_i` falls, the first frame counts as a run of one.
- R6: A cycle with `b1_err_i` high clears the inconsistency count. A strobe in that same cycle is not counted.
- R7: A pulse on `delta_clr_i` or `event_clr_i` clears its flag in the next cycle. If a set and a clear arrive in the same cycle, the flag stays set.
- R8: `delta_irq_o` = `delta_o` AND NOT `delta_mask_i`, and `event_irq_o` = `event_o` AND NOT `event_mask_i`. `aps_irq_o` = `delta_o` AND NOT `aps_mask_i`.
- R9: A threshold value of 0 on either threshold input acts as 1.
- R10: After reset, `aps_val_o` is 0 and all flags and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe, once per frame, qualifying the K bytes |
| k1_i | input | 8 | Received K1 byte |
| k2_i | input | 8 | Received K2 byte |
| oof_i | input | 1 | Framer out-of-frame indication |
| b1_err_i | input | 1 | One-cycle B1 parity error indication |
| persist_thr_i | input | 4 | Consecutive identical frames needed for acceptance |
| incons_thr_i | input | 4 | Frames without acceptance before an event (default 12) |
| delta_clr_i | input | 1 | Clear pulse for the delta flag |
| event_clr_i | input | 1 | Clear pulse for the event flag |
| delta_mask_i | input | 1 | Mask for delta_irq_o |
| event_mask_i | input | 1 | Mask for event_irq_o |
| aps_mask_i | input | 1 | Mask for aps_irq_o |
| aps_val_o | output | 13 | Accepted APS value |
| delta_o | output | 1 | Sticky accepted-value-changed flag |
| event_o | output | 1 | Sticky inconsistency flag |
| delta_irq_o | output | 1 | Masked delta interrupt |
| event_irq_o | output | 1 | Masked inconsistency interrupt |
| aps_irq_o | output | 1 | Dedicated protection-switching interrupt |

## Verification
The assertions assume that `frame_stb_i` is a single-cycle pulse with at least one idle cycle between frames. They also assume that the thresholds change only between frames and that the K bytes are valid whenever the strobe is high. The stimulus drives every input at the falling clock edge and returns the strobe, the clear pulses and `b1_err_i` to low after one cycle. Out-of-frame is applied both on its own and together with a strobe.

// File: rtl/aps_mon_pkg.sv
package aps_mon_pkg;
   localparam int FLAG_DELTA = 0;
   localparam int FLAG_EVENT = 1;
   localparam int NUM_FLAGS  = 2;
   localparam int DEF_INCONS_THR = 12;
endpackage

// File: rtl/aps_run_tracker.sv
module aps_run_tracker #(
   parameter int VAL_W = 13,
   parameter int THR_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             stb_i,
   input  logic             oof_i,
   input  logic [VAL_W-1:0] sample_i,
   input  logic [THR_W-1:0] thr_i,
   output logic             qualify_o
);
   localparam logic [THR_W-1:0] RUN_MAX = '1;
   localparam logic [THR_W-1:0] ONE     = THR_W'(1);

   logic [VAL_W-1:0] prev_q;
   logic [THR_W-1:0] run_q, run_n, thr_eff;
   logic             take;

   assign take    = stb_i && !oof_i;
   assign thr_eff = (thr_i == '0) ? ONE : thr_i;

   always_comb begin
      run_n = run_q;
      if (take) begin
         if (run_q != '0 && sample_i == prev_q)
            run_n = (run_q == RUN_MAX) ? run_q : run_q + ONE;
         else
            run_n = ONE;
      end
   end

   assign qualify_o = take && (run_n >= thr_eff);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= '0;
         prev_q <= '0;
      end else if (oof_i) begin
         run_q  <= '0;
      end else if (stb_i) begin
         run_q  <= run_n;
         prev_q <= sample_i;
      end
   end

   // R5: out-of-frame empties the run
   a_r5_oof_clears_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oof_i |=> (run_q == '0));
   // R2: any accepted strobe leaves a run of at least one
   a_r2_run_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && !oof_i) |=> (run_q != '0));
endmodule

// File: rtl/aps_incons_ctr.sv
module aps_incons_ctr #(
   parameter int THR_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             stb_i,
   input  logic             oof_i,
   input  logic             b1_err_i,
   input  logic             qualify_i,
   input  logic [THR_W-1:0] thr_i,
   output logic             event_o
);
   localparam logic [THR_W-1:0] ONE = THR_W'(1);

   logic [THR_W-1:0] cnt_q, cnt_inc, thr_eff;
   logic             clear, count;

   assign thr_eff = (thr_i == '0) ? ONE : thr_i;
   assign cnt_inc = cnt_q + ONE;
   assign clear   = oof_i || b1_err_i;
   assign count   = stb_i && !clear && !qualify_i;
   assign event_o = count && (cnt_inc >= thr_eff);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (stb_i) begin
         if (qualify_i || event_o)
            cnt_q <= '0;
         else
            cnt_q <= cnt_inc;
      end
   end

   // R6: B1 errors and out-of-frame zero the count
   a_r6_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear |=> (cnt_q == '0));
   // R4: an accepted frame restarts the count
   a_r4_qualify_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && qualify_i) |=> (cnt_q == '0));
endmodule

// File: rtl/aps_sticky_flag.sv
module aps_sticky_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   input  logic mask_i,
   output logic flag_o,
   output logic irq_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         flag_o <= 1'b0;
      else
         flag_o <= set_i || (flag_o && !clr_i);
   end

   assign irq_o = flag_o && !mask_i;

   // R7: a flag persists until cleared
   a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o);
   // R7: set wins over clear
   a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> flag_o);
   // R7: clear without set drops the flag
   a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/aps_persist_mon.sv
module aps_persist_mon
   import aps_mon_pkg::*;
#(
   parameter int K_W     = 8,
   parameter int K2_KEEP = 5,
   parameter int THR_W   = 4
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      frame_stb_i,
   input  logic [K_W-1:0]            k1_i,
   input  logic [K_W-1:0]            k2_i,
   input  logic                      oof_i,
   input  logic                      b1_err_i,
   input  logic [THR_W-1:0]          persist_thr_i,
   input  logic [THR_W-1:0]          incons_thr_i,
   input  logic                      delta_clr_i,
   input  logic                      event_clr_i,
   input  logic                      delta_mask_i,
   input  logic                      event_mask_i,
   input  logic                      aps_mask_i,
   output logic [K_W+K2_KEEP-1:0]    aps_val_o,
   output logic                      delta_o,
   output logic                      event_o,
   output logic                      delta_irq_o,
   output logic                      event_irq_o,
   output logic                      aps_irq_o
);
   localparam int VAL_W = K_W + K2_KEEP;

   generate
      if (K_W < 1)               begin : g_bad_kw  $error("K_W must be positive"); end
      if (K2_KEEP < 1 || K2_KEEP > K_W) begin : g_bad_keep $error("K2_KEEP out of range"); end
      if (THR_W < 1 || THR_W > 16) begin : g_bad_thr $error("THR_W out of range"); end
      if (DEF_INCONS_THR >= (1 << THR_W)) begin : g_bad_def $error("THR_W too narrow for default"); end
   endgenerate

   logic [VAL_W-1:0]     sample, acc_q;
   logic                 qualify, incons_evt, val_chg;
   logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg_mask, flg_q, flg_irq;

   assign sample = {k1_i, k2_i[K_W-1 -: K2_KEEP]};

   aps_run_tracker #(.VAL_W(VAL_W), .THR_W(THR_W)) run_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stb_i     (frame_stb_i),
      .oof_i     (oof_i),
      .sample_i  (sample),
      .thr_i     (persist_thr_i),
      .qualify_o (qualify)
   );

   aps_incons_ctr #(.THR_W(THR_W)) inc_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stb_i     (frame_stb_i),
      .oof_i     (oof_i),
      .b1_err_i  (b1_err_i),
      .qualify_i (qualify),
      .thr_i     (incons_thr_i),
      .event_o   (incons_evt)
   );

   assign val_chg = qualify && (sample != acc_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         acc_q <= '0;
      else if (qualify)
         acc_q <= sample;
   end

   assign flg_set[FLAG_DELTA]  = val_chg;
   assign flg_set[FLAG_EVENT]  = incons_evt;
   assign flg_clr[FLAG_DELTA]  = delta_clr_i;
   assign flg_clr[FLAG_EVENT]  = event_clr_i;
   assign flg_mask[FLAG_DELTA] = delta_mask_i;
   assign flg_mask[FLAG_EVENT] = event_mask_i;

   generate
      for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
         aps_sticky_flag flag_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (flg_set[f]),
            .clr_i  (flg_clr[f]),
            .mask_i (flg_mask[f]),
            .flag_o (flg_q[f]),
            .irq_o  (flg_irq[f])
         );
      end
   endgenerate

   assign aps_val_o   = acc_q;
   assign delta_o     = flg_q[FLAG_DELTA];
   assign event_o     = flg_q[FLAG_EVENT];
   assign delta_irq_o = flg_irq[FLAG_DELTA];
   assign event_irq_o = flg_irq[FLAG_EVENT];
   assign aps_irq_o   = flg_q[FLAG_DELTA] && !aps_mask_i;

   // R3: the accepted value only moves on a strobe outside out-of-frame
   a_r3_val_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!frame_stb_i || oof_i) |=> $stable(aps_val_o));
   // R3: a change in the accepted value is always flagged
   a_r3_change_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(aps_val_o) |-> delta_o);
   // R8: masked interrupts stay low
   a_r8_delta_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      delta_mask_i |-> !delta_irq_o);
   a_r8_aps_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      aps_mask_i |-> !aps_irq_o);
endmodule

// File: tb/aps_persist_mon_tb_top.sv
module aps_persist_mon_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0, oof = 1'b0, b1 = 1'b0;
   logic [7:0]  k1 = '0, k2 = '0;
   logic [3:0]  pthr = 4'd3, ithr = 4'd4;
   logic        dclr = 1'b0, eclr = 1'b0, dmask = 1'b0, emask = 1'b0, amask = 1'b0;
   logic [12:0] val;
   logic        delta, evt, dirq, eirq, airq;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   aps_persist_mon dut_i (
      .clk_i(clk), .rst_ni(rst_n), .frame_stb_i(stb), .k1_i(k1), .k2_i(k2),
      .oof_i(oof), .b1_err_i(b1), .persist_thr_i(pthr), .incons_thr_i(ithr),
      .delta_clr_i(dclr), .event_clr_i(eclr), .delta_mask_i(dmask),
      .event_mask_i(emask), .aps_mask_i(amask), .aps_val_o(val),
      .delta_o(delta), .event_o(evt), .delta_irq_o(dirq), .event_irq_o(eirq),
      .aps_irq_o(airq)
   );

   // {k1, k2, expected value, expected delta, expected event}, thresholds 3 and 4
   localparam logic [30:0] VEC [10] = '{
      {8'h5A, 8'hC8, 13'h0000, 1'b0, 1'b0},
      {8'h5A, 8'hC8, 13'h0000, 1'b0, 1'b0},
      {8'h5A, 8'hC8, 13'h0B59, 1'b1, 1'b0},
      {8'h5A, 8'hCF, 13'h0B59, 1'b1, 1'b0},
      {8'h3C, 8'h10, 13'h0B59, 1'b1, 1'b0},
      {8'hF0, 8'hF8, 13'h0B59, 1'b1, 1'b0},
      {8'h3C, 8'h10, 13'h0B59, 1'b1, 1'b0},
      {8'hF0, 8'hF8, 13'h0B59, 1'b1, 1'b1},
      {8'hF0, 8'hF8, 13'h0B59, 1'b1, 1'b1},
      {8'hF0, 8'hFB, 13'h1E1F, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic frame(input logic [7:0] a, input logic [7:0] b, input logic o, input logic dc);
      @(negedge clk);
      k1 = a; k2 = b; stb = 1'b1; oof = o; dclr = dc;
      @(negedge clk);
      stb = 1'b0; oof = 1'b0; dclr = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_oof();
      @(negedge clk); oof = 1'b1; @(negedge clk); oof = 1'b0;
   endtask

   task automatic pulse_b1();
      @(negedge clk); b1 = 1'b1; @(negedge clk); b1 = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); dclr = 1'b1; eclr = 1'b1; @(negedge clk); dclr = 1'b0; eclr = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 value", 32'(val), 32'h0);
      chk("R10 flags", {27'd0, delta, evt, dirq, eirq, airq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4: table walk
      for (int i = 0; i < 10; i++) begin
         frame(VEC[i][30:23], VEC[i][22:15], 1'b0, 1'b0);
         chk($sformatf("R1/R2 value step %0d", i), 32'(val), 32'(VEC[i][14:2]));
         chk($sformatf("R3 delta step %0d", i), 32'(delta), 32'(VEC[i][1]));
         chk($sformatf("R4 event step %0d", i), 32'(evt), 32'(VEC[i][0]));
      end

      // R8: masking
      @(negedge clk); dmask = 1'b1;
      @(negedge clk);
      chk("R8 delta irq masked", 32'(dirq), 32'h0);
      chk("R8 aps irq own mask", 32'(airq), 32'h1);
      chk("R8 event irq", 32'(eirq), 32'h1);
      amask = 1'b1; emask = 1'b1; dmask = 1'b0;
      @(negedge clk);
      chk("R8 aps irq masked", 32'(airq), 32'h0);
      chk("R8 event irq masked", 32'(eirq), 32'h0);
      chk("R8 delta irq unmasked", 32'(dirq), 32'h1);
      amask = 1'b0; emask = 1'b0;

      // R7: clear pulses
      clear_flags();
      chk("R7 delta cleared", 32'(delta), 32'h0);
      chk("R7 event cleared", 32'(evt), 32'h0);

      // R9 and R7: threshold 0 acts as 1, set wins over clear
      pthr = 4'd0;
      frame(8'h3C, 8'h17, 1'b0, 1'b1);
      chk("R9 single frame accepted", 32'(val), 32'h0782);
      chk("R7 set wins", 32'(delta), 32'h1);

      // R5: out-of-frame restarts the run
      pthr = 4'd2;
      frame(8'h5A, 8'hC8, 1'b0, 1'b0);
      pulse_oof();
      frame(8'h5A, 8'hC8, 1'b0, 1'b0);
      chk("R5 run restarted after oof", 32'(val), 32'h0782);
      frame(8'h5A, 8'hC8, 1'b0, 1'b0);
      chk("R2 accepted after two", 32'(val), 32'h0B59);
      frame(8'hF0, 8'hF8, 1'b1, 1'b0);
      chk("R5 strobe during oof ignored", 32'(val), 32'h0B59);
      frame(8'hF0, 8'hF8, 1'b0, 1'b0);
      chk("R5 first frame after oof is run one", 32'(val), 32'h0B59);

      // R6: B1 error clears the inconsistency count
      pthr = 4'd15; ithr = 4'd3;
      pulse_b1();
      clear_flags();
      frame(8'h3C, 8'h10, 1'b0, 1'b0);
      frame(8'hF0, 8'hF8, 1'b0, 1'b0);
      pulse_b1();
      frame(8'h3C, 8'h10, 1'b0, 1'b0);
      frame(8'hF0, 8'hF8, 1'b0, 1'b0);
      chk("R6 count cleared by b1", 32'(evt), 32'h0);
      frame(8'h3C, 8'h10, 1'b0, 1'b0);
      chk("R4 event after three", 32'(evt), 32'h1);
      // R4: count restarted after the report
      @(negedge clk); eclr = 1'b1; @(negedge clk); eclr = 1'b0;
      frame(8'hF0, 8'hF8, 1'b0, 1'b0);
      frame(8'h3C, 8'h10, 1'b0, 1'b0);
      chk("R4 restart after report", 32'(evt), 32'h0);
      frame(8'hF0, 8'hF8, 1'b0, 1'b0);
      chk("R4 second report", 32'(evt), 32'h1);

      done = 1'b1;
      summary();
   end
endmodule